// File: doc/BRIEF.md
# Oversampled Synchronous Frame Receiver

This block takes a slow synchronous serial line, a receive clock plus receive data at roughly 1 MHz, and samples both with a much faster system clock. Each input goes through a synchronizer chain. Every rising edge of the receive clock becomes a one-cycle shift enable, and the data bit is taken on that enable. The framer stays disarmed until it has seen a run of idle-high (marking) bits. After that it looks for start bits and collects frames made of a start bit, eight data bits and a parity bit. It checks the parity of each frame and hands the byte to a packer.

The packer gathers bytes into 32-bit words. It can reverse the byte order within the word and the bit order within each byte. A word leaves as a write strobe to an external FIFO in two cases: when four bytes are in, or when a programmed packet length ends with a partial word. The block has no storage at its output. `out_valid` is high for exactly one cycle for each word. `out_ready` reports that the FIFO has room, and the block does not wait for it. If `out_ready` is low during the strobe, the word is dropped and a sticky overflow flag is set.

Dropping `rx_en` returns the receiver to its idle state and clears both sticky flags. The receiver runs independently of any transmitter, so loop-back is possible.

Top module: `sync_frame_rx`

## Requirements
- R1: Each rising edge of `rx_clk_in`, after the synchronizers, produces exactly one single-cycle internal shift enable, and `rx_dat_in` is sampled on that enable. No other event samples data.
- R2: After reset or after `rx_en` rises, a start bit is accepted only once at least MARK_MIN (default 10) consecutive samples of 1 have been taken. A sample of 0 before then restarts the count.
- R3: A frame is a 0 start bit, then eight data bits with the least significant bit first, then one parity bit. After the parity bit the receiver hunts for the next start bit at once, with no new marking run needed.
- R4: Parity is odd: the ones in the data byte plus the parity bit must total an odd count. A mismatch sets the sticky `par_err`, and the byte is still packed and delivered.
- R5: With both reversal controls low, the n-th byte of a word (n = 0..3) occupies bits 8n+7:8n. The first received bit therefore lands in bit 0 and the last in bit 31.
- R6: With `cfg_byte_rev` high, the n-th byte of a word occupies byte lane 3-n.
- R7: With `cfg_bit_rev` high, the bit order within each byte is mirrored, so the first received bit of a byte lands in that lane's bit 7. With both controls high, the first bit of a word lands in bit 31.
- R8: When the fourth byte of a word completes, the word is written out as one strobe.
- R9: When `cfg_len` is nonzero and `cfg_len` bytes have been received since the packet began, the current word is written out even if partial. Lanes that were not filled are zero, and the next byte starts a new packet and a new word. A `cfg_len` of 0 means there is no packet limit.
- R10: `out_valid` is a one-cycle strobe. If `out_ready` is low in that cycle, the word is lost and the sticky `ovf_err` is set.
- R11: While `rx_en` is low, no data is accepted, any partial word is discarded, both flags read 0, and `out_valid` stays low. The same holds out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receiver enable; low clears state and flags |
| rx_clk_in | input | 1 | Asynchronous line clock |
| rx_dat_in | input | 1 | Asynchronous line data |
| cfg_len | input | LEN_W | Packet length in bytes, 0 = unlimited |
| cfg_byte_rev | input | 1 | Reverse byte lanes within the word |
| cfg_bit_rev | input | 1 | Mirror bits within each byte |
| out_valid | output | 1 | One-cycle word write strobe |
| out_ready | input | 1 | Output FIFO has room |
| out_data | output | 32 | Packed word |
| par_err | output | 1 | Sticky parity error |
| ovf_err | output | 1 | Sticky overflow (word dropped) |

## Verification
The packer is tried with eight-byte unlimited packets, single words under each reversal setting, and packets of 6 and 3 bytes. These patterns separate the full-word push from the length flush, and lane placement from bit mirroring. Arming is tried with a short marking run and with no marking run after re-enable, and both must yield no word. A full marking run must then let the next frame through. A frame with wrong parity must still deliver its word and raise the flag. A strobe made while `out_ready` is low must be lost rather than held.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [1:0] {
    FS_MARK = 2'd0,
    FS_HUNT = 2'd1,
    FS_DATA = 2'd2,
    FS_PAR  = 2'd3
  } frame_st_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_in,
  input  logic dat_in,
  output logic shift_en,
  output logic dat_smp
);
  logic [STAGES-1:0] ck_s;
  logic [STAGES-1:0] dt_s;
  logic              ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s    <= '0;
      dt_s    <= '1;
      ck_prev <= 1'b0;
    end else begin
      ck_s    <= {ck_s[STAGES-2:0], clk_in};
      dt_s    <= {dt_s[STAGES-2:0], dat_in};
      ck_prev <= ck_s[STAGES-1];
    end
  end

  assign shift_en = ck_s[STAGES-1] & ~ck_prev;
  assign dat_smp  = dt_s[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import sfr_pkg::*;
#(
  parameter int   MARK_MIN = 10,
  parameter logic ODD_PAR  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              shift_en,
  input  logic              dat,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_dat,
  output logic              byte_perr
);
  localparam int MC_W = $clog2(MARK_MIN + 1);
  localparam int BC_W = $clog2(BYTE_W);

  frame_st_t         st;
  logic [MC_W-1:0]   mark_cnt;
  logic [BC_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_MARK;
      mark_cnt  <= '0;
      bit_cnt   <= '0;
      sh        <= '0;
      byte_vld  <= 1'b0;
      byte_dat  <= '0;
      byte_perr <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (!enable) begin
        st       <= FS_MARK;
        mark_cnt <= '0;
      end else if (shift_en) begin
        case (st)
          FS_MARK: begin
            if (!dat) mark_cnt <= '0;
            else if (mark_cnt == MC_W'(MARK_MIN - 1)) begin
              st       <= FS_HUNT;
              mark_cnt <= '0;
            end else mark_cnt <= mark_cnt + 1'b1;
          end
          FS_HUNT: begin
            if (!dat) begin
              st      <= FS_DATA;
              bit_cnt <= '0;
            end
          end
          FS_DATA: begin
            sh      <= {dat, sh[BYTE_W-1:1]};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BC_W'(BYTE_W - 1)) st <= FS_PAR;
          end
          FS_PAR: begin
            byte_vld  <= 1'b1;
            byte_dat  <= sh;
            byte_perr <= ((^sh) ^ dat) != ODD_PAR;
            st        <= FS_HUNT;
          end
          default: st <= FS_MARK;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import sfr_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         byte_vld,
  input  logic [BYTE_W-1:0]            byte_dat,
  input  logic [LEN_W-1:0]             cfg_len,
  input  logic                         cfg_byte_rev,
  input  logic                         cfg_bit_rev,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [WORD_BYTES*BYTE_W-1:0] out_data,
  output logic                         ovf_err
);
  localparam int WORD_W = WORD_BYTES * BYTE_W;
  localparam int LANE_W = $clog2(WORD_BYTES);

  logic [LANE_W-1:0] lane_cnt;
  logic [LANE_W-1:0] lane;
  logic [LEN_W-1:0]  pkt_cnt;
  logic [WORD_W-1:0] word, word_nxt;
  logic [BYTE_W-1:0] byte_mir, byte_in;
  logic              len_hit, push;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mir
    assign byte_mir[i] = byte_dat[BYTE_W-1-i];
  end

  assign byte_in = cfg_bit_rev ? byte_mir : byte_dat;
  assign lane    = cfg_byte_rev ? LANE_W'(WORD_BYTES - 1) - lane_cnt : lane_cnt;
  assign len_hit = (cfg_len != '0) && (pkt_cnt + LEN_W'(1) == cfg_len);
  assign push    = byte_vld && (lane_cnt == LANE_W'(WORD_BYTES - 1) || len_hit);

  always_comb begin
    word_nxt = word;
    for (int k = 0; k < WORD_BYTES; k++)
      if (lane == LANE_W'(k)) word_nxt[k*BYTE_W +: BYTE_W] = byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_cnt  <= '0;
      pkt_cnt   <= '0;
      word      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      ovf_err   <= 1'b0;
    end else if (!enable) begin
      lane_cnt  <= '0;
      pkt_cnt   <= '0;
      word      <= '0;
      out_valid <= 1'b0;
      ovf_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (out_valid && !out_ready) ovf_err <= 1'b1;
      if (byte_vld) begin
        pkt_cnt <= (len_hit || cfg_len == '0) ? '0 : pkt_cnt + 1'b1;
        if (push) begin
          out_valid <= 1'b1;
          out_data  <= word_nxt;
          word      <= '0;
          lane_cnt  <= '0;
        end else begin
          word     <= word_nxt;
          lane_cnt <= lane_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx
  import sfr_pkg::*;
#(
  parameter int   MARK_MIN    = 10,
  parameter logic ODD_PAR     = 1'b1,
  parameter int   LEN_W       = 16,
  parameter int   SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rx_clk_in,
  input  logic             rx_dat_in,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_byte_rev,
  input  logic             cfg_bit_rev,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             par_err,
  output logic             ovf_err
);
  logic              shift_en, dat_smp;
  logic              byte_vld, byte_perr;
  logic [BYTE_W-1:0] byte_dat;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clk_in(rx_clk_in), .dat_in(rx_dat_in),
    .shift_en(shift_en), .dat_smp(dat_smp)
  );

  rx_framer #(.MARK_MIN(MARK_MIN), .ODD_PAR(ODD_PAR)) u_frm (
    .clk(clk), .rst_n(rst_n), .enable(rx_en), .shift_en(shift_en),
    .dat(dat_smp), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .byte_perr(byte_perr)
  );

  rx_word_packer #(.LEN_W(LEN_W), .WORD_BYTES(4)) u_pack (
    .clk(clk), .rst_n(rst_n), .enable(rx_en), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .cfg_len(cfg_len), .cfg_byte_rev(cfg_byte_rev),
    .cfg_bit_rev(cfg_bit_rev), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .ovf_err(ovf_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      par_err <= 1'b0;
    else if (!rx_en)                 par_err <= 1'b0;
    else if (byte_vld && byte_perr)  par_err <= 1'b1;
  end
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic shift_en,
  input logic byte_vld,
  input logic byte_perr,
  input logic out_valid,
  input logic out_ready,
  input logic par_err,
  input logic ovf_err
);
  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_ovf_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_en && out_valid && !out_ready)) |-> ovf_err);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_en && ovf_err)) |-> ovf_err);

  p_par_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_en && byte_vld && byte_perr)) |-> par_err);

  p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!out_valid && !par_err && !ovf_err));
endmodule

bind sync_frame_rx sfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .shift_en(shift_en),
  .byte_vld(byte_vld), .byte_perr(byte_perr), .out_valid(out_valid),
  .out_ready(out_ready), .par_err(par_err), .ovf_err(ovf_err)
);

// File: tb/test_sync_frame_rx.sv
`timescale 1ns/1ps
module test_sync_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        rx_clk_in = 1'b0;
  logic        rx_dat_in = 1'b1;
  logic [15:0] cfg_len = '0;
  logic        cfg_byte_rev = 1'b0;
  logic        cfg_bit_rev = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        par_err, ovf_err;

  int          n_chk = 0, n_bad = 0, seen = 0, dropped = 0, cyc = 0;
  logic [31:0] exp_q[$];
  logic [7:0]  pk[$];
  logic [31:0] mon_w;
  string       cur_req = "R5";

  always #2.5 clk = ~clk;

  sync_frame_rx i_sync_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_clk_in(rx_clk_in),
    .rx_dat_in(rx_dat_in), .cfg_len(cfg_len), .cfg_byte_rev(cfg_byte_rev),
    .cfg_bit_rev(cfg_bit_rev), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .par_err(par_err), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
    if (rst_n && out_valid) begin
      seen++;
      if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected word"}, out_data, 32'd0);
      else begin
        mon_w = exp_q.pop_front();
        if (out_ready) chk(out_data == mon_w, cur_req, out_data, mon_w);
        else dropped++;
      end
    end
  end

  function automatic logic [7:0] mir(input logic [7:0] b);
    for (int i = 0; i < 8; i++) mir[i] = b[7-i];
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_dat_in = b;
    rx_clk_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_clk_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit((~^b) ^ bad);
  endtask

  task automatic send_packet();
    int n = pk.size();
    for (int s = 0; s < n; s += 4) begin
      logic [31:0] w = '0;
      for (int j = 0; j < 4 && s + j < n; j++) begin
        int lane = cfg_byte_rev ? 3 - j : j;
        w[lane*8 +: 8] = cfg_bit_rev ? mir(pk[s+j]) : pk[s+j];
      end
      exp_q.push_back(w);
    end
    for (int i = 0; i < n; i++) send_frame(pk[i], 1'b0);
    pk.delete();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !par_err && !ovf_err, "R11 reset state",
        {29'd0, out_valid, par_err, ovf_err}, 32'd0);

    rx_en = 1'b1;
    cfg_len = 16'd1;
    cur_req = "R2";
    send_ones(5);
    send_frame(8'h00, 1'b0);
    repeat (10) @(negedge clk);
    chk(seen == 0, "R2 short marking run", 32'(seen), 32'd0);
    send_ones(12);

    cfg_len = 16'd0;
    cur_req = "R5";
    s0 = seen;
    pk = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 8'h5A, 8'h0F, 8'hF0};
    send_packet();
    chk(seen - s0 == 2, "R8 words per 8 bytes", 32'(seen - s0), 32'd2);
    chk(exp_q.size() == 0, "R3 back-to-back frames", 32'(exp_q.size()), 32'd0);
    chk(!par_err, "R4 no error on good parity", 32'(par_err), 32'd0);

    cfg_byte_rev = 1'b1;
    cur_req = "R6";
    pk = '{8'h01, 8'h23, 8'h45, 8'h67};
    send_packet();
    cfg_byte_rev = 1'b0;
    cfg_bit_rev = 1'b1;
    cur_req = "R7";
    pk = '{8'h01, 8'h80, 8'h3C, 8'hE2};
    send_packet();
    cfg_byte_rev = 1'b1;
    pk = '{8'h01, 8'h02, 8'h04, 8'h08};
    send_packet();
    cfg_byte_rev = 1'b0;
    cfg_bit_rev = 1'b0;

    cfg_len = 16'd6;
    cur_req = "R9";
    s0 = seen;
    pk = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h12, 8'h34};
    send_packet();
    chk(seen - s0 == 2, "R9 partial flush count", 32'(seen - s0), 32'd2);
    cfg_len = 16'd3;
    cfg_byte_rev = 1'b1;
    pk = '{8'hAA, 8'hBB, 8'hCC};
    send_packet();
    cfg_byte_rev = 1'b0;
    chk(exp_q.size() == 0, "R9 all words seen", 32'(exp_q.size()), 32'd0);

    cfg_len = 16'd1;
    cur_req = "R4";
    exp_q.push_back(32'h0000_0077);
    send_frame(8'h77, 1'b1);
    repeat (10) @(negedge clk);
    chk(par_err, "R4 parity flag", 32'(par_err), 32'd1);
    chk(exp_q.size() == 0, "R4 bad byte delivered", 32'(exp_q.size()), 32'd0);

    cur_req = "R10";
    out_ready = 1'b0;
    chk(!ovf_err, "R10 no overflow yet", 32'(ovf_err), 32'd0);
    pk = '{8'h5C};
    send_packet();
    chk(ovf_err && dropped == 1, "R10 drop sets flag", {31'd0, ovf_err}, 32'd1);
    out_ready = 1'b1;
    pk = '{8'hC5};
    send_packet();
    chk(ovf_err, "R10 flag sticky", 32'(ovf_err), 32'd1);
    chk(exp_q.size() == 0, "R1 one word per frame", 32'(exp_q.size()), 32'd0);

    rx_en = 1'b0;
    cur_req = "R11";
    repeat (3) @(negedge clk);
    chk(!par_err && !ovf_err, "R11 flags cleared", {30'd0, par_err, ovf_err}, 32'd0);
    s0 = seen;
    send_ones(12);
    send_frame(8'h00, 1'b0);
    repeat (10) @(negedge clk);
    chk(seen == s0, "R11 disabled ignores line", 32'(seen - s0), 32'd0);
    rx_en = 1'b1;
    send_frame(8'h00, 1'b0);
    repeat (10) @(negedge clk);
    chk(seen == s0, "R2 rearm needs marking", 32'(seen - s0), 32'd0);
    send_ones(12);
    cur_req = "R2";
    pk = '{8'h9E};
    send_packet();
    chk(seen == s0 + 1, "R2 armed after marking", 32'(seen - s0), 32'd1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule